// File: doc/BRIEF.md
# Segmented DAC Input Decoder

This block is the digital front end of one channel of a current-steering video DAC. On each rising clock edge it captures a 10-bit straight-binary sample. It splits the sample into a 4-bit upper field and a 6-bit lower field. The upper field is decoded into a 15-bit thermometer code that drives equal-weight unit current switches. The lower field drives binary-weighted switches without change. The switch controls are registered a second time, so every switch changes on the same edge, one cycle after the sample was taken.

Two power-down inputs act on the output register asynchronously: one for the channel and one shared by the whole converter. Either one forces every switch control to the off state (logic 0) at once, with no clock edge needed. The per-channel input of one instance has no effect on any other instance. A multi-channel converter uses one instance per channel and ties the shared power-down input to all of them.

Top module: `seg_dac_decoder`

## Requirements
- R1: The 10-bit input `code_i` is captured only on the rising edge of `clk`; changes between edges do not reach the outputs.
- R2: Thermometer bit k of `unit_sw_o` (k = 0..14) is 1 exactly when the value of `code_i[9:6]` is greater than k.
- R3: The ones in `unit_sw_o` always form a contiguous run starting at bit 0.
- R4: `bin_sw_o[5:0]` equals `code_i[5:0]` bit for bit, bit 0 being the least significant switch.
- R5: A code captured at edge N appears at both outputs just after edge N+1, and the outputs do not change between edges.
- R6: While `chan_pd_i` is high, both outputs are 0, and they become 0 within the same cycle it rises, without a clock edge.
- R7: While `glob_pd_i` is high, both outputs are 0 whatever `chan_pd_i` is set to.
- R8: After both power-down inputs go low, the outputs stay 0 until the next rising edge. At that edge they load the decode of the code captured at the previous edge.
- R9: Code 0 turns every switch off. Code 1023 turns on all 15 unit switches and all 6 binary switches.
- R10: While `rst_n` is low, both outputs and the captured code are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_pd_i | input | 1 | Power-down for this channel, active high |
| glob_pd_i | input | 1 | Power-down shared by all channels, active high |
| code_i | input | 10 | Straight-binary sample |
| unit_sw_o | output | 15 | Thermometer controls for the unit current switches |
| bin_sw_o | output | 6 | Controls for the binary-weighted switches |

## Verification
A stale or corrupted value in the capture register shows up at the outputs exactly one edge later, as a wrong unit count or wrong binary bits. The bench therefore samples each code after the second edge and also checks that the outputs have not changed after the first edge. A fault in the thermometer decoder shows up at once as a wrong count of ones or as a gap in the run of ones, so every one of the 16 upper-field values is applied. A power-down path that waits for the clock shows up as nonzero outputs one nanosecond after the power-down input rises. A release that lets stale data through shows up before the first edge after release.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;

  // Default field split of the sample word.
  localparam int unsigned CODE_W_DEF = 10;
  localparam int unsigned HI_W_DEF   = 4;

  // True when a unit switch at position k must conduct for upper field value v.
  function automatic logic unit_on(input int unsigned v, input int unsigned k);
    return v > k;
  endfunction

  // The number of unit switches that conduct for upper field value v.
  function automatic int unsigned unit_count(input int unsigned v);
    return v;
  endfunction

endpackage

// File: rtl/sdd_in_reg.sv
module sdd_in_reg #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/sdd_therm_dec.sv
module sdd_therm_dec #(
  parameter int unsigned HI_W = 4,
  localparam int unsigned UNITS = (1 << HI_W) - 1
) (
  input  logic [HI_W-1:0]  hi,
  output logic [UNITS-1:0] therm
);

  import seg_dac_pkg::*;

  // One magnitude comparator for each unit switch.
  for (genvar k = 0; k < UNITS; k++) begin : g_unit
    assign therm[k] = unit_on(int'(hi), k);
  end

endmodule

// File: rtl/sdd_out_reg.sv
module sdd_out_reg #(
  parameter int unsigned UNITS = 15,
  parameter int unsigned LO_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd,
  input  logic [UNITS-1:0] therm_d,
  input  logic [LO_W-1:0]  bin_d,
  output logic [UNITS-1:0] therm_q,
  output logic [LO_W-1:0]  bin_q
);

  // Power-down clears the switch controls asynchronously. Release waits for the next edge.
  always_ff @(posedge clk or negedge rst_n or posedge pd) begin
    if (!rst_n) begin
      therm_q <= '0;
      bin_q   <= '0;
    end else if (pd) begin
      therm_q <= '0;
      bin_q   <= '0;
    end else begin
      therm_q <= therm_d;
      bin_q   <= bin_d;
    end
  end

  // R6: power-down holds every switch control off.
  p_pd_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> (therm_q == '0 && bin_q == '0));

  // R8: an edge that still sees power-down keeps the outputs off.
  p_release_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && $past(pd)) |-> $stable(therm_q) && $stable(bin_q));

endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder #(
  parameter int unsigned CODE_W = seg_dac_pkg::CODE_W_DEF,
  parameter int unsigned HI_W   = seg_dac_pkg::HI_W_DEF,
  localparam int unsigned LO_W  = CODE_W - HI_W,
  localparam int unsigned UNITS = (1 << HI_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_pd_i,
  input  logic              glob_pd_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [UNITS-1:0]  unit_sw_o,
  output logic [LO_W-1:0]   bin_sw_o
);

  import seg_dac_pkg::*;

  // Named internal events for the assertions
  logic [CODE_W-1:0] code_q;
  logic [HI_W-1:0]   hi_field;
  logic [LO_W-1:0]   lo_field;
  logic [UNITS-1:0]  therm_dec;
  logic              pd_any;

  assign pd_any   = chan_pd_i | glob_pd_i;
  assign hi_field = code_q[CODE_W-1 -: HI_W];
  assign lo_field = code_q[LO_W-1:0];

  sdd_in_reg #(.W(CODE_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (code_i),
    .q     (code_q)
  );

  sdd_therm_dec #(.HI_W(HI_W)) u_dec (
    .hi    (hi_field),
    .therm (therm_dec)
  );

  sdd_out_reg #(.UNITS(UNITS), .LO_W(LO_W)) u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .pd      (pd_any),
    .therm_d (therm_dec),
    .bin_d   (lo_field),
    .therm_q (unit_sw_o),
    .bin_q   (bin_sw_o)
  );

  // R3: the decoded ones form one run that starts at bit 0.
  p_therm_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((therm_dec & (therm_dec + 1'b1)) == '0));

  // R2: the count of ones matches the upper field value.
  p_therm_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(therm_dec) == unit_count(int'(hi_field)));

  // R5: with no power-down across an edge, the outputs show the code captured one edge earlier.
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_any && $past(!pd_any)) |->
      (bin_sw_o == $past(lo_field) &&
       $countones(unit_sw_o) == unit_count(int'($past(hi_field)))));

  // R7: the shared power-down wins over the per-channel input.
  p_glob_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
    glob_pd_i |-> (unit_sw_o == '0 && bin_sw_o == '0));

endmodule

// File: tb/test_seg_dac_decoder.sv
`timescale 1ns/1ps
module test_seg_dac_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_pd_i = 1'b0;
  logic        glob_pd_i = 1'b0;
  logic [9:0]  code_i = '0;
  logic [14:0] unit_sw_o;
  logic [5:0]  bin_sw_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seg_dac_decoder i_seg_dac_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_pd_i (chan_pd_i),
    .glob_pd_i (glob_pd_i),
    .code_i    (code_i),
    .unit_sw_o (unit_sw_o),
    .bin_sw_o  (bin_sw_o)
  );

  // Expected switch pattern, built from the requirements: v low ones, then the low field.
  function automatic logic [20:0] expect_of(input logic [9:0] c);
    logic [14:0] t;
    t = 15'((32'd1 << c[9:6]) - 32'd1);
    return {t, c[5:0]};
  endfunction

  task automatic check(input string req, input logic [20:0] exp_v);
    n_vec++;
    if ({unit_sw_o, bin_sw_o} !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h/%h expected %h/%h", req,
               unit_sw_o, bin_sw_o, exp_v[20:6], exp_v[5:0]);
    end
  endtask

  // Drive between edges, capture at one edge, observe after the next one.
  task automatic apply(input logic [9:0] c, input string req);
    @(negedge clk) code_i = c;
    @(posedge clk);
    @(posedge clk);
    #1 check(req, expect_of(c));
  endtask

  task automatic t_reset;
    #1 check("R10 reset", 21'd0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_extremes;
    apply(10'd0,    "R9 code 0");
    apply(10'd1023, "R9 code 1023");
    apply(10'd0,    "R9 back to 0");
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 16; i++) begin
      logic [9:0] c;
      c = 10'((i << 6) | ((i * 7 + 3) % 64));
      apply(c, "R2 R3 R4 upper sweep");
    end
    apply(10'h2AA, "R4 alternating low bits");
    apply(10'h155, "R4 alternating low bits inverse");
  endtask

  task automatic t_latency;
    apply(10'h0C5, "R5 first code");
    @(negedge clk) code_i = 10'h3B2;
    @(posedge clk);
    #1 check("R5 old value after capture edge", expect_of(10'h0C5));
    @(negedge clk) code_i = 10'h011;   // changes between edges must not leak (R1)
    #1 check("R1 mid-cycle change ignored", expect_of(10'h0C5));
    @(posedge clk);
    #1 check("R5 new value after second edge", expect_of(10'h3B2));
    @(posedge clk);
    #1 check("R1 next capture", expect_of(10'h011));
  endtask

  task automatic t_chan_pd;
    apply(10'h3FF, "R6 setup");
    @(negedge clk);
    #0.5 chan_pd_i = 1'b1;
    #0.5 check("R6 async off without edge", 21'd0);
    @(posedge clk);
    #1 check("R6 held off across edge", 21'd0);
  endtask

  task automatic t_glob_pd;
    @(negedge clk) chan_pd_i = 1'b0; glob_pd_i = 1'b1;
    #1 check("R7 global off with channel low", 21'd0);
    @(posedge clk);
    #1 check("R7 global held", 21'd0);
    chan_pd_i = 1'b1;
    @(posedge clk);
    #1 check("R7 both high", 21'd0);
  endtask

  task automatic t_release;
    @(negedge clk) code_i = 10'h1E7;
    @(posedge clk);                     // 1E7 captured while powered down
    @(negedge clk) chan_pd_i = 1'b0; glob_pd_i = 1'b0; code_i = 10'h000;
    #1 check("R8 off after release before edge", 21'd0);
    @(posedge clk);
    #1 check("R8 first edge loads captured code", expect_of(10'h1E7));
    @(posedge clk);
    #1 check("R8 pipeline resumes", expect_of(10'h000));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_extremes();
    t_sweep();
    t_latency();
    t_chan_pd();
    t_glob_pd();
    t_release();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule